// File: doc/BRIEF.md
# Partition Label Register and Generator

This block holds the 64-bit partitioning control register for the second privilege level. It turns the register's contents into a partition ID and a monitoring group that tag each outgoing memory request. A per-request flag picks the instruction pair of fields or the data pair. A global enable bit in the register forces both labels to their default value of zero when it is clear.

When a third privilege level is implemented, the enable bit no longer has its own storage. It reads back the third level's enable input, and writes to it are dropped. Otherwise the enable bit is an ordinary read/write bit.

Two trap-control bits for the lower-level registers are stored and read back. On warm reset they take 1 when no third level exists, and 0 otherwise, because their value is unspecified in that case. All reserved bits read as zero. The labels are registered, so each label reflects the register contents and request flag of the cycle before.

Top module: `partLabelGen`

## Requirements
- R1: When the effective enable (bit 63 as read back) is 0, partId and monGroup are both 0 on the cycle after, whatever the other fields hold.
- R2: When enabled and reqIsInstr is 1, partId takes bits [15:0] and monGroup takes bits [39:32].
- R3: When enabled and reqIsInstr is 0 (load or store), partId takes bits [31:16] and monGroup takes bits [47:40].
- R4: A write stores bits [49:0] of wrData, and rdData returns them at the same positions from the cycle after the write edge.
- R5: With hasLvl3 = 1, rdData bit 63 equals lvl3Enable, and writes to bit 63 leave the stored enable unchanged.
- R6: With hasLvl3 = 0, bit 63 is read/write and takes wrData[63] on a write.
- R7: On reset, bit 63 is 0 and bits [47:0] are 0. Bits 49 and 48 become 1 if hasLvl3 = 0 and 0 if hasLvl3 = 1.
- R8: rdData bits [62:50] always read 0, and writes to them are ignored.
- R9: partId and monGroup are registered. A write, or a change of reqIsInstr or lvl3Enable, shows in them one clock edge after it shows in rdData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low warm reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 64 | Register write data |
| hasLvl3 | input | 1 | Third privilege level implemented |
| lvl3Enable | input | 1 | Third level's global enable bit |
| reqIsInstr | input | 1 | 1 = instruction fetch, 0 = load/store |
| partId | output | 16 | Partition ID label |
| monGroup | output | 8 | Monitoring group label |
| rdData | output | 64 | Register read value |

## Verification
The bench aims at the enable bit's ownership changing with hasLvl3. A design that stored the bit while the third level is present would let a dropped write reappear once hasLvl3 falls back to 0. It loads all-ones data to catch reserved bits that leak, and swaps the request flag to catch instruction and data fields that are crossed. It resets once with each value of hasLvl3 to catch trap bits with a fixed reset value. It samples the labels right after a write edge to catch a label path that is combinational or two cycles late.

// File: rtl/partLabelPkg.sv
package partLabelPkg;
  localparam int CFG_W  = 64;
  localparam int EN_BIT = 63;

  typedef struct packed {
    logic loadFields;   // update trap and label fields
    logic loadEnable;   // update locally stored enable bit
    logic enEff;        // effective global enable
    logic pickInstr;    // use instruction-side fields
  } ctrlStrobes_t;
endpackage

// File: rtl/partLabelCtrl.sv
module partLabelCtrl
  import partLabelPkg::*;
(
  input  logic         wrEn,
  input  logic         hasLvl3,
  input  logic         lvl3Enable,
  input  logic         enStore,
  input  logic         reqIsInstr,
  output ctrlStrobes_t strb
);
  always_comb begin
    strb.loadFields = wrEn;
    strb.loadEnable = wrEn & ~hasLvl3;
    strb.enEff      = hasLvl3 ? lvl3Enable : enStore;
    strb.pickInstr  = reqIsInstr;
  end
endmodule

// File: rtl/partLabelDp.sv
module partLabelDp
  import partLabelPkg::*;
#(
  parameter int PART_W   = 16,
  parameter int PMG_W    = 8,
  parameter int DEF_PART = 0,
  parameter int DEF_PMG  = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [CFG_W-1:0]   wrData,
  input  logic               hasLvl3,
  output logic               enStore,
  output logic [PART_W-1:0]  partId,
  output logic [PMG_W-1:0]   monGroup,
  output logic [CFG_W-1:0]   rdData
);
  localparam int PARTI_LSB = 0;
  localparam int PARTD_LSB = PARTI_LSB + PART_W;
  localparam int PMGI_LSB  = PARTD_LSB + PART_W;
  localparam int PMGD_LSB  = PMGI_LSB + PMG_W;
  localparam int TRAP1_BIT = PMGD_LSB + PMG_W;
  localparam int TRAP0_BIT = TRAP1_BIT + 1;

  logic [PART_W-1:0] partI, partD;
  logic [PMG_W-1:0]  pmgI, pmgD;
  logic              trap0, trap1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enStore <= 1'b0;
      trap0   <= ~hasLvl3;
      trap1   <= ~hasLvl3;
      partI   <= '0;
      partD   <= '0;
      pmgI    <= '0;
      pmgD    <= '0;
    end else begin
      if (strb.loadEnable) enStore <= wrData[EN_BIT];
      if (strb.loadFields) begin
        trap0 <= wrData[TRAP0_BIT];
        trap1 <= wrData[TRAP1_BIT];
        partI <= wrData[PARTI_LSB +: PART_W];
        partD <= wrData[PARTD_LSB +: PART_W];
        pmgI  <= wrData[PMGI_LSB +: PMG_W];
        pmgD  <= wrData[PMGD_LSB +: PMG_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      partId   <= PART_W'(DEF_PART);
      monGroup <= PMG_W'(DEF_PMG);
    end else if (!strb.enEff) begin
      partId   <= PART_W'(DEF_PART);
      monGroup <= PMG_W'(DEF_PMG);
    end else if (strb.pickInstr) begin
      partId   <= partI;
      monGroup <= pmgI;
    end else begin
      partId   <= partD;
      monGroup <= pmgD;
    end
  end

  always_comb begin
    rdData                         = '0;
    rdData[EN_BIT]                 = strb.enEff;
    rdData[TRAP0_BIT]              = trap0;
    rdData[TRAP1_BIT]              = trap1;
    rdData[PMGD_LSB +: PMG_W]      = pmgD;
    rdData[PMGI_LSB +: PMG_W]      = pmgI;
    rdData[PARTD_LSB +: PART_W]    = partD;
    rdData[PARTI_LSB +: PART_W]    = partI;
  end
endmodule

// File: rtl/partLabelGen.sv
module partLabelGen
  import partLabelPkg::*;
#(
  parameter int PART_W   = 16,
  parameter int PMG_W    = 8,
  parameter int DEF_PART = 0,
  parameter int DEF_PMG  = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [63:0]        wrData,
  input  logic               hasLvl3,
  input  logic               lvl3Enable,
  input  logic               reqIsInstr,
  output logic [PART_W-1:0]  partId,
  output logic [PMG_W-1:0]   monGroup,
  output logic [63:0]        rdData
);
  ctrlStrobes_t strb;
  logic         enStore;

  partLabelCtrl i_ctrl (
    .wrEn(wrEn), .hasLvl3(hasLvl3), .lvl3Enable(lvl3Enable),
    .enStore(enStore), .reqIsInstr(reqIsInstr), .strb(strb)
  );

  partLabelDp #(
    .PART_W(PART_W), .PMG_W(PMG_W), .DEF_PART(DEF_PART), .DEF_PMG(DEF_PMG)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .hasLvl3(hasLvl3),
    .enStore(enStore), .partId(partId), .monGroup(monGroup), .rdData(rdData)
  );
endmodule

// File: rtl/partLabelChk.sv
module partLabelChk #(
  parameter int PART_W   = 16,
  parameter int PMG_W    = 8,
  parameter int DEF_PART = 0,
  parameter int DEF_PMG  = 0
) (
  input logic               clk,
  input logic               rstN,
  input logic               hasLvl3,
  input logic               lvl3Enable,
  input logic               reqIsInstr,
  input logic [PART_W-1:0]  partId,
  input logic [PMG_W-1:0]   monGroup,
  input logic [63:0]        rdData
);
  localparam int PARTD_LSB = PART_W;
  localparam int PMGI_LSB  = 2 * PART_W;
  localparam int PMGD_LSB  = PMGI_LSB + PMG_W;

  a_r1_default_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdData[63]) |-> (partId == PART_W'(DEF_PART) && monGroup == PMG_W'(DEF_PMG)));

  a_r2_instr_fields: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rdData[63]) && $past(reqIsInstr)) |->
      (partId == $past(rdData[PART_W-1:0]) && monGroup == $past(rdData[PMGI_LSB +: PMG_W])));

  a_r3_data_fields: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rdData[63]) && !$past(reqIsInstr)) |->
      (partId == $past(rdData[PARTD_LSB +: PART_W]) && monGroup == $past(rdData[PMGD_LSB +: PMG_W])));

  a_r5_enable_mirror: assert property (@(posedge clk) disable iff (!rstN)
    hasLvl3 |-> rdData[63] == lvl3Enable);

  a_r7_trap_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> rdData[49:48] == {2{!hasLvl3}});

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdData[62:50] == 13'd0);
endmodule

bind partLabelGen partLabelChk #(
  .PART_W(PART_W), .PMG_W(PMG_W), .DEF_PART(DEF_PART), .DEF_PMG(DEF_PMG)
) i_chk (
  .clk(clk), .rstN(rstN), .hasLvl3(hasLvl3), .lvl3Enable(lvl3Enable),
  .reqIsInstr(reqIsInstr), .partId(partId), .monGroup(monGroup), .rdData(rdData)
);

// File: tb/test_partLabelGen.sv
module test_partLabelGen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic        hasLvl3 = 1'b0;
  logic        lvl3Enable = 1'b0;
  logic        reqIsInstr = 1'b0;
  logic [15:0] partId;
  logic [7:0]  monGroup;
  logic [63:0] rdData;

  int nChecks = 0;
  int nErrs = 0;

  // bench model
  logic        mEn;
  logic        mT0, mT1;
  logic [47:0] mFld;

  always #4 clk = ~clk;

  partLabelGen i_partLabelGen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .hasLvl3(hasLvl3),
    .lvl3Enable(lvl3Enable), .reqIsInstr(reqIsInstr), .partId(partId),
    .monGroup(monGroup), .rdData(rdData)
  );

  function automatic logic effEn();
    return hasLvl3 ? lvl3Enable : mEn;
  endfunction

  function automatic logic [63:0] expRd();
    return {effEn(), 13'd0, mT0, mT1, mFld};
  endfunction

  function automatic logic [23:0] expLabel();
    if (!effEn()) return 24'd0;
    if (reqIsInstr) return {mFld[15:0], mFld[39:32]};
    return {mFld[31:16], mFld[47:40]};
  endfunction

  function automatic string labelTag();
    if (!effEn()) return "R1";
    return reqIsInstr ? "R2" : "R3";
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset(logic h3);
    @(negedge clk);
    rstN = 1'b0; hasLvl3 = h3; wrEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mEn = 1'b0; mT0 = !h3; mT1 = !h3; mFld = '0;
    chk("R7 reset value", rdData, expRd());
    chk("R7 reset label", {40'd0, partId, monGroup}, 64'd0);
  endtask

  // one write (optional) followed by readback and label checks
  task automatic step(logic doWr, logic [63:0] d, logic instr, logic h3, logic l3);
    @(negedge clk);
    wrEn = doWr; wrData = d; reqIsInstr = instr; hasLvl3 = h3; lvl3Enable = l3;
    @(negedge clk);
    wrEn = 1'b0;
    if (doWr) begin
      mT0 = d[49]; mT1 = d[48]; mFld = d[47:0];
      if (!h3) mEn = d[63];
    end
    chk(h3 ? "R4/R5/R8 readback" : "R4/R6/R8 readback", rdData, expRd());
    @(negedge clk);
    chk(labelTag(), {40'd0, partId, monGroup}, {40'd0, expLabel()});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErrs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end

  initial begin
    logic [23:0] oldLbl;
    process::self().srandom(32'd1234);
    doReset(1'b0);
    // R8/R6: all ones including reserved bits
    step(1'b1, 64'hFFFF_A5C3_BEEF_1234, 1'b1, 1'b0, 1'b0);
    chk("R8 reserved zero", {51'd0, rdData[62:50]}, 64'd0);
    step(1'b0, 64'd0, 1'b0, 1'b0, 1'b0);          // R3 data side
    // R9 latency: label lags readback by one edge
    oldLbl = expLabel();
    @(negedge clk);
    wrEn = 1'b1; wrData = 64'h8000_5A3C_7777_9999;
    @(negedge clk);
    wrEn = 1'b0; mT0 = 1'b0; mT1 = 1'b0; mFld = 48'h5A3C_7777_9999;
    chk("R9 readback updated", rdData, expRd());
    chk("R9 label still old", {40'd0, partId, monGroup}, {40'd0, oldLbl});
    @(negedge clk);
    chk("R9 label new", {40'd0, partId, monGroup}, {40'd0, expLabel()});
    // R5: enable write ignored when level 3 exists
    step(1'b1, 64'h0000_1122_3344_5566, 1'b1, 1'b1, 1'b0);  // R1 default
    step(1'b0, 64'd0, 1'b1, 1'b1, 1'b1);                      // R5 mirror on
    step(1'b0, 64'd0, 1'b0, 1'b0, 1'b0);                      // R5 stored en still 1
    chk("R5 write to enable ignored", {63'd0, rdData[63]}, 64'd1);
    step(1'b1, 64'h0000_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1);   // R6 clear, R1
    // reset with level 3 present
    doReset(1'b1);
    for (int i = 0; i < 300; i++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      step(($urandom % 4) != 0, d, $urandom % 2, ($urandom % 3) == 0, $urandom % 2);
    end
    doReset(1'b0);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end
endmodule